// File: doc/BRIEF.md
# Board Interrupt Level Encoder

This block gathers thirteen level-sensitive interrupt request lines from the peripherals on a board and turns them into one 4-bit interrupt level for the CPU. Each request line owns a fixed bit in a 16-bit live-request word and a fixed priority code. Software enables sources through a 16-bit enable register. Of the sources that are both requesting and enabled, the one with the smallest priority code wins. The block drives the bitwise inverse of that code, so an idle board gives level 0 and the most urgent source gives the highest level.

A small synchronous register port sits in a 64-byte window of 16-bit registers. It holds the enable register, a power-off control that emits a one-cycle shutdown request, a read-only version word, and a general-purpose output port that returns its last written value. All other offsets read as zero and drop writes. The level output, the read data and the shutdown request all come straight from flip-flops.

Top module: `brd_irq_enc`

## Requirements
- R1: Request input index k maps to a fixed enable/monitor bit position. Indices 0..12 map to bit positions 11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15 in that order. Bit positions 1, 2 and 3 have no source.
- R2: Request input index k carries priority code k (0 to 12). Among the sources that are requesting and whose enable bit is set, the smallest code wins. With no such source the selected code is 15.
- R3: `irq_level_o` equals the selected code XOR 15. It is therefore non-zero whenever at least one enabled source is requesting.
- R4: `irq_level_o` is 0 when no enabled source is requesting, and during and just after reset.
- R5: The enable register is at byte offset 0x00 and can be read and written in full. A write changes `irq_level_o` on the same clock edge that stores the write.
- R6: The power-off register is at offset 0x30 and reads as 0. A write whose data bit 0 is 1 makes `halt_req_o` high for exactly the one cycle after that edge. A write with bit 0 clear does not raise it.
- R7: The version register is at offset 0x32. It always reads 0x0010 and ignores writes.
- R8: The output-port register is at offset 0x36 and reads back the last value written to it.
- R9: Any other byte offset in the 6-bit window, odd offsets included, reads as 0. A write to such an offset changes no register and no output.
- R10: `irq_level_o` changes on the first rising clock edge after a request input changes. `bus_rdata_o` is loaded on the rising edge that samples a read strobe and holds until the next read.
- R11: Reset (active-low `rst_n`) clears the enable register, the output port, the read data and the shutdown request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req_i | input | 13 | Level interrupt requests, index = priority code |
| bus_sel_i | input | 1 | Register access strobe, one cycle per access |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 6 | Byte offset in the register window |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Registered read data |
| irq_level_o | output | 4 | Encoded interrupt level to the CPU |
| halt_req_o | output | 1 | One-cycle shutdown request |

## Verification
The bench builds the block with its default parameters: 13 sources, 16-bit registers, a 6-bit byte address and version 0x0010. With these values the whole source table is in play, so every request-to-bit mapping and every priority pairing can be reached by random request and enable patterns. The 6-bit window is small enough to sweep every offset for the read-as-zero and write-ignored rules. Directed cases cover single-source levels, an enable write that changes the winner on the same edge, and power-off writes with bit 0 clear and with bit 0 set.

// File: rtl/brd_irq_pkg.sv
package brd_irq_pkg;

    localparam int N_SRC   = 13;
    localparam int REG_W   = 16;
    localparam int CODE_W  = 4;
    localparam int POS_W   = $clog2(REG_W);

    typedef logic [POS_W-1:0]  pos_t;
    typedef logic [CODE_W-1:0] code_t;

    // byte offsets inside the 64-byte window (software map)
    localparam int OFS_ENABLE = 'h00;
    localparam int OFS_HALT   = 'h30;
    localparam int OFS_VER    = 'h32;
    localparam int OFS_PORT   = 'h36;

    // bit position in the monitor / enable words owned by each source
    function automatic pos_t src_pos(input int idx);
        case (idx)
            0:       return pos_t'(11);
            1:       return pos_t'(9);
            2:       return pos_t'(8);
            3:       return pos_t'(12);
            4:       return pos_t'(10);
            5:       return pos_t'(6);
            6:       return pos_t'(5);
            7:       return pos_t'(4);
            8:       return pos_t'(7);
            9:       return pos_t'(14);
            10:      return pos_t'(13);
            11:      return pos_t'(0);
            default: return pos_t'(15);
        endcase
    endfunction

    // priority code of each source: smaller wins
    function automatic code_t src_code(input int idx);
        return code_t'(idx);
    endfunction

endpackage

// File: rtl/brd_irq_gather.sv
module brd_irq_gather
    import brd_irq_pkg::*;
#(
    parameter int NUM_SRC = N_SRC,
    parameter int DATA_W  = REG_W
) (
    input  logic [NUM_SRC-1:0] req,
    output logic [DATA_W-1:0]  mon
);

    // each monitor bit is the OR of the sources placed on it
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        logic hit;
        always_comb begin
            hit = 1'b0;
            for (int i = 0; i < NUM_SRC; i++) begin
                if (src_pos(i) == pos_t'(b)) begin
                    hit = hit | req[i];
                end
            end
        end
        assign mon[b] = hit;
    end

endmodule

// File: rtl/brd_irq_prio.sv
module brd_irq_prio
    import brd_irq_pkg::*;
#(
    parameter int NUM_SRC = N_SRC,
    parameter int DATA_W  = REG_W
) (
    input  logic [DATA_W-1:0] active,
    output code_t             best
);

    always_comb begin
        best = '1;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (active[src_pos(i)] && (src_code(i) < best)) begin
                best = src_code(i);
            end
        end
    end

endmodule

// File: rtl/brd_irq_regs.sv
module brd_irq_regs
    import brd_irq_pkg::*;
#(
    parameter int              ADDR_W  = 6,
    parameter int              DATA_W  = REG_W,
    parameter logic [DATA_W-1:0] VERSION = 16'h0010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] enable_d,
    output logic [DATA_W-1:0] enable_q,
    output logic [DATA_W-1:0] rdata,
    output logic              halt
);

    localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFS_ENABLE);
    localparam logic [ADDR_W-1:0] A_HALT   = ADDR_W'(OFS_HALT);
    localparam logic [ADDR_W-1:0] A_VER    = ADDR_W'(OFS_VER);
    localparam logic [ADDR_W-1:0] A_PORT   = ADDR_W'(OFS_PORT);

    logic              wr_stb;
    logic              rd_stb;
    logic [DATA_W-1:0] port_q;
    logic [DATA_W-1:0] port_d;
    logic [DATA_W-1:0] rd_val;
    logic              halt_d;

    assign wr_stb = sel & wr;
    assign rd_stb = sel & ~wr;

    always_comb begin
        enable_d = enable_q;
        port_d   = port_q;
        halt_d   = 1'b0;
        if (wr_stb) begin
            unique case (addr)
                A_ENABLE: enable_d = wdata;
                A_PORT:   port_d   = wdata;
                A_HALT:   halt_d   = wdata[0];
                default:  ;
            endcase
        end
    end

    always_comb begin
        unique case (addr)
            A_ENABLE: rd_val = enable_q;
            A_PORT:   rd_val = port_q;
            A_VER:    rd_val = VERSION;
            default:  rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
            port_q   <= '0;
            rdata    <= '0;
            halt     <= 1'b0;
        end else begin
            enable_q <= enable_d;
            port_q   <= port_d;
            halt     <= halt_d;
            if (rd_stb) begin
                rdata <= rd_val;
            end
        end
    end

endmodule

// File: rtl/brd_irq_enc.sv
module brd_irq_enc
    import brd_irq_pkg::*;
#(
    parameter int                NUM_SRC = N_SRC,
    parameter int                ADDR_W  = 6,
    parameter int                DATA_W  = REG_W,
    parameter int                LVL_W   = CODE_W,
    parameter logic [DATA_W-1:0] VERSION = 16'h0010
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_req_i,
    input  logic               bus_sel_i,
    input  logic               bus_wr_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [DATA_W-1:0]  bus_wdata_i,
    output logic [DATA_W-1:0]  bus_rdata_o,
    output logic [LVL_W-1:0]   irq_level_o,
    output logic               halt_req_o
);

    logic [DATA_W-1:0] mon_w;
    logic [DATA_W-1:0] enable_d;
    logic [DATA_W-1:0] enable_q;
    code_t             best_code;
    logic [LVL_W-1:0]  lvl_q;

    brd_irq_gather #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_gather (
        .req (irq_req_i),
        .mon (mon_w)
    );

    brd_irq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .VERSION(VERSION)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (bus_sel_i),
        .wr       (bus_wr_i),
        .addr     (bus_addr_i),
        .wdata    (bus_wdata_i),
        .enable_d (enable_d),
        .enable_q (enable_q),
        .rdata    (bus_rdata_o),
        .halt     (halt_req_o)
    );

    // encode on the next-state enable so a write takes effect on its own edge
    brd_irq_prio #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_prio (
        .active (mon_w & enable_d),
        .best   (best_code)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= '0;
        end else begin
            lvl_q <= ~LVL_W'(best_code);
        end
    end

    assign irq_level_o = lvl_q;

endmodule

// File: rtl/brd_irq_enc_chk.sv
module brd_irq_enc_chk #(
    parameter int                ADDR_W  = 6,
    parameter int                DATA_W  = 16,
    parameter int                LVL_W   = 4,
    parameter logic [DATA_W-1:0] VERSION = 16'h0010
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel_i,
    input logic              bus_wr_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [DATA_W-1:0] bus_wdata_i,
    input logic [DATA_W-1:0] bus_rdata_o,
    input logic [LVL_W-1:0]  irq_level_o,
    input logic              halt_req_o,
    input logic [DATA_W-1:0] mon_w,
    input logic [DATA_W-1:0] enable_q
);

    p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(mon_w) & enable_q) == '0) |-> (irq_level_o == '0));

    p_pending_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(mon_w) & enable_q) != '0) |-> (irq_level_o != '0));

    p_enable_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel_i && bus_wr_i && bus_addr_i == ADDR_W'('h00))
        |=> (enable_q == $past(bus_wdata_i)));

    p_enable_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel_i && bus_wr_i && bus_addr_i == ADDR_W'('h00))
        |=> $stable(enable_q));

    p_halt_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req_o |-> $past(bus_sel_i && bus_wr_i
                             && bus_addr_i == ADDR_W'('h30) && bus_wdata_i[0]));

    p_version_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel_i && !bus_wr_i && bus_addr_i == ADDR_W'('h32))
        |=> (bus_rdata_o == VERSION));

    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel_i && !bus_wr_i) |=> $stable(bus_rdata_o));

endmodule

bind brd_irq_enc brd_irq_enc_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LVL_W(LVL_W), .VERSION(VERSION)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel_i   (bus_sel_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .irq_level_o (irq_level_o),
    .halt_req_o  (halt_req_o),
    .mon_w       (mon_w),
    .enable_q    (enable_q)
);

// File: tb/tb_brd_irq_enc.sv
module tb_brd_irq_enc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] req = '0;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [5:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [3:0]  lvl;
    logic        halt;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [15:0] sw_enable = '0;
    logic [15:0] sw_port = '0;

    always #5 clk = ~clk;

    brd_irq_enc dut (
        .clk (clk), .rst_n (rst_n), .irq_req_i (req),
        .bus_sel_i (sel), .bus_wr_i (wr), .bus_addr_i (addr),
        .bus_wdata_i (wdata), .bus_rdata_o (rdata),
        .irq_level_o (lvl), .halt_req_o (halt)
    );

    function automatic int bit_of(input int k);
        int t[13] = '{11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15};
        return t[k];
    endfunction

    function automatic logic [3:0] exp_level(input logic [12:0] r, input logic [15:0] en);
        int win = 15;
        for (int k = 12; k >= 0; k--) begin
            if (r[k] && en[bit_of(k)]) win = k;
        end
        return 4'(win ^ 15);
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [5:0] a, input logic [15:0] d);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [5:0] a, output logic [15:0] d);
        sel = 1'b1; wr = 1'b0; addr = a;
        @(negedge clk);
        sel = 1'b0;
        d = rdata;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        chk("R11 level after reset", 16'(lvl), 16'h0);
        chk("R11 halt after reset", 16'(halt), 16'h0);
        chk("R11 rdata after reset", rdata, 16'h0);
        bus_rd(6'h00, v); chk("R11 enable reset", v, 16'h0);
        bus_rd(6'h36, v); chk("R11 port reset", v, 16'h0);

        // R4 requests with everything disabled
        req = '1; @(negedge clk);
        chk("R4 all requests, enable zero", 16'(lvl), 16'h0);

        // R5 enable write takes effect on its own edge; R1/R3 single sources
        for (int k = 0; k < 13; k++) begin
            req = '0; req[k] = 1'b1;
            sw_enable = 16'h0001 << bit_of(k);
            bus_wr(6'h00, sw_enable);
            chk($sformatf("R1 R3 R5 single source %0d", k), 16'(lvl), 16'(k ^ 15));
            bus_wr(6'h00, ~sw_enable);
            chk($sformatf("R1 source %0d masked by own bit", k), 16'(lvl), 16'h0);
        end
        bus_rd(6'h00, v); chk("R5 enable readback", v, ~sw_enable);

        // R10 level changes only at the next edge after a request change
        sw_enable = 16'hffff; bus_wr(6'h00, sw_enable);
        req = 13'h0800; @(negedge clk);
        chk("R10 settled level", 16'(lvl), 16'(11 ^ 15));
        req = 13'h0001; #1;
        chk("R10 level holds before edge", 16'(lvl), 16'(11 ^ 15));
        @(negedge clk);
        chk("R10 level after edge", 16'(lvl), 16'hf);

        // R2 winner by smallest code, enable write on same edge changes winner
        req = 13'h0006; sw_enable = 16'hffff; @(negedge clk);
        chk("R2 code 1 beats code 2", 16'(lvl), 16'(1 ^ 15));
        sw_enable = 16'hfdff; bus_wr(6'h00, sw_enable);
        chk("R2 R5 disabling winner exposes code 2", 16'(lvl), 16'(2 ^ 15));

        // R6 power-off
        bus_wr(6'h30, 16'hfffe);
        chk("R6 no halt with bit0 clear", 16'(halt), 16'h0);
        bus_wr(6'h30, 16'h0001);
        chk("R6 halt pulse", 16'(halt), 16'h1);
        @(negedge clk);
        chk("R6 halt one cycle", 16'(halt), 16'h0);
        bus_rd(6'h30, v); chk("R6 reads zero", v, 16'h0);

        // R7 version
        bus_wr(6'h32, 16'h5a5a);
        bus_rd(6'h32, v); chk("R7 version ignores write", v, 16'h0010);

        // R8 output port
        sw_port = 16'hc3a5; bus_wr(6'h36, sw_port);
        bus_rd(6'h36, v); chk("R8 port readback", v, sw_port);

        // R9 every other offset: reads zero, writes change nothing
        for (int a = 0; a < 64; a++) begin
            if (a != 'h00 && a != 'h30 && a != 'h32 && a != 'h36) begin
                bus_wr(6'(a), 16'hffff);
                chk($sformatf("R9 no halt at %0h", a), 16'(halt), 16'h0);
                bus_rd(6'(a), v);
                chk($sformatf("R9 read zero at %0h", a), v, 16'h0);
            end
        end
        bus_rd(6'h00, v); chk("R9 enable unchanged", v, sw_enable);
        bus_rd(6'h36, v); chk("R9 port unchanged", v, sw_port);
        chk("R9 level unchanged", 16'(lvl), 16'(exp_level(req, sw_enable)));

        // R10 read data holds between reads
        bus_rd(6'h36, v);
        sel = 1'b0; addr = 6'h32; @(negedge clk);
        chk("R10 rdata holds", rdata, sw_port);

        // random: R1 R2 R3 R4 R5
        for (int n = 0; n < 400; n++) begin
            req = 13'($urandom);
            if (($urandom % 4) == 0) req = '0;
            if (($urandom % 3) == 0) begin
                sw_enable = 16'($urandom);
                bus_wr(6'h00, sw_enable);
            end else begin
                @(negedge clk);
            end
            chk("R2 R3 random level", 16'(lvl), 16'(exp_level(req, sw_enable)));
        end
        bus_rd(6'h00, v); chk("R5 random enable readback", v, sw_enable);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule